// File: doc/BRIEF.md
# Predicated Non-Faulting Vector Load Sequencer

This block loads one vector register's worth of unsigned halfwords from memory, one element after another, under a per-byte predicate. A memory access that reports a fault is never turned into an exception. Instead the fault is recorded by clearing bits of a first-fault mask, and every element from the faulting one onward is written as zero. A start pulse captures a 64-bit base address, a signed 4-bit immediate, an element-size code, the predicate and the incoming first-fault mask. A one-cycle done pulse then presents the finished result vector and the updated mask. Both values stay on the outputs until the next start.

Memory is reached through a request channel (valid/ready, address only) and a response channel (valid/ready, 16-bit data plus a fault flag). A request stays asserted with a fixed address until the memory accepts it. At most one request is in flight. The block raises its response ready only while it waits for the answer to that request, so the memory can stall either channel for any number of cycles. The vector length in bits is a parameter and must be a multiple of 128.

Top module: `ldnf_seq`

## Requirements
- R1: The size code picks the element width W: 0 selects 16 bits, 1 selects 32 bits, and 2 or 3 select 64 bits. The element count is N = VLEN/W. Element e reads the halfword at base + 2*(imm*N + e), with the address arithmetic wrapping modulo 2^64.
- R2: The immediate is a signed value from -8 to 7. It is always scaled by N, however many predicate bits are set.
- R3: A loaded halfword is zero-extended into bits [e*W +: W] of the result.
- R4: Element e is active when predicate bit e*(W/8) is set. An inactive element issues no request, cannot fault and is written as zero.
- R5: When no element is active, no request is issued, done still follows, and the mask leaves unchanged.
- R6: The first active element whose response carries the fault flag clears all W/8 mask bits of its own group and of every later group. Its result is zero. Groups before it are unchanged.
- R7: After a fault response, no further request is issued in that operation. All later elements are zero.
- R8: Once an element's lowest mask bit is found clear, that element and every later element are zero, even without any fault.
- R9: done is a one-cycle pulse. The outputs hold their values until the next start. A start while an operation runs is ignored. After reset, done and req_valid are low.
- R10: Requests are issued in ascending element order. req_valid and req_addr hold steady until req_ready, and a new request never appears while a response is outstanding.
- R11: rsp_ready is high only while a response is outstanding. A response is taken on the cycle where rsp_valid and rsp_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (used only when idle) |
| base_addr | input | 64 | Base byte address |
| imm | input | 4 | Signed vector-multiple offset |
| esize | input | 2 | Element size code |
| pred | input | VLEN/8 | Predicate, one bit per byte |
| ffr_in | input | VLEN/8 | Incoming first-fault mask |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | 64 | Halfword address |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Block accepts response |
| rsp_data | input | 16 | Returned halfword |
| rsp_fault | input | 1 | Access was not performed |
| done | output | 1 | Operation finished pulse |
| result | output | VLEN | Result vector |
| ffr_out | output | VLEN/8 | Updated first-fault mask |

## Verification
The bound checker watches the port-level protocol on every cycle. It checks that requests hold steady under back-pressure, that only one request is in flight, that rsp_ready appears only while a response is owed, that done lasts one cycle, and that no request follows a fault response within an operation. The checker cannot see address arithmetic, zero-extension, predicate decoding, the shape of the cleared mask or zeroing after a clear mask bit. Only the bench scenarios show these, by comparing each request address and each final result and mask against an independent model, across all size codes, both ends of the immediate range, faults at the first and at a middle element, faults on inactive addresses, and a start issued mid-operation.

// File: rtl/ldnf_pkg.sv
package ldnf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SCAN = 3'd1,
    ST_REQ  = 3'd2,
    ST_WAIT = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;

  // log2 of element width in halfwords: 0 -> 16b, 1 -> 32b, 2/3 -> 64b
  function automatic logic [1:0] size_shift(input logic [1:0] code);
    return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/ldnf_addr_gen.sv
module ldnf_addr_gen #(
  parameter int VLB = 128,
  parameter int HW  = VLB / 16,
  parameter int IW  = $clog2(HW)
) (
  input  logic [63:0]   base,
  input  logic [3:0]    imm,
  input  logic [1:0]    shift,
  input  logic [IW-1:0] idx,
  output logic [63:0]   addr
);
  logic [63:0]        elem_cnt;
  logic signed [63:0] imm_ext;
  logic signed [63:0] off;

  always_comb begin
    elem_cnt = 64'(HW) >> shift;
    imm_ext  = $signed({{60{imm[3]}}, imm});
    off      = imm_ext * $signed(elem_cnt) + $signed({{(64-IW){1'b0}}, idx});
    addr     = base + {off[62:0], 1'b0};
  end
endmodule

// File: rtl/ldnf_elem_view.sv
module ldnf_elem_view #(
  parameter int VLB = 128,
  parameter int HW  = VLB / 16,
  parameter int PB  = VLB / 8,
  parameter int IW  = $clog2(HW),
  parameter int PIW = $clog2(PB)
) (
  input  logic [PB-1:0] pred,
  input  logic [PB-1:0] ffr,
  input  logic [1:0]    shift,
  input  logic [IW-1:0] idx,
  output logic          active,
  output logic          ffr_low,
  output logic [PB-1:0] grp_mask
);
  logic [1:0]     lgb;
  logic [PIW-1:0] pos;

  always_comb begin
    lgb     = shift + 2'd1;
    pos     = PIW'(idx) << lgb;
    active  = pred[pos];
    ffr_low = ffr[pos];
  end

  for (genvar p = 0; p < PB; p++) begin : g_grp
    assign grp_mask[p] = ((PIW'(p) >> lgb) == PIW'(idx));
  end
endmodule

// File: rtl/ldnf_seq.sv
module ldnf_seq #(
  parameter int VLB = 128,
  localparam int HW  = VLB / 16,
  localparam int PB  = VLB / 8,
  localparam int IW  = $clog2(HW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [63:0]    base_addr,
  input  logic [3:0]     imm,
  input  logic [1:0]     esize,
  input  logic [PB-1:0]  pred,
  input  logic [PB-1:0]  ffr_in,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [63:0]    req_addr,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [15:0]    rsp_data,
  input  logic           rsp_fault,
  output logic           done,
  output logic [VLB-1:0] result,
  output logic [PB-1:0]  ffr_out
);
  import ldnf_pkg::*;

  seq_state_t     st;
  logic [IW-1:0]  idx;
  logic [63:0]    base_q;
  logic [3:0]     imm_q;
  logic [1:0]     shift_q;
  logic [PB-1:0]  pred_q;
  logic [PB-1:0]  ffr_q;
  logic [VLB-1:0] res_q;
  logic           faulted_q;
  logic           unknown_q;

  logic           active;
  logic           ffr_low;
  logic [PB-1:0]  grp_mask;
  logic [IW-1:0]  last_idx;
  logic [IW-1:0]  slot;
  logic           last_elem;

  ldnf_addr_gen #(.VLB(VLB)) u_addr (
    .base (base_q),
    .imm  (imm_q),
    .shift(shift_q),
    .idx  (idx),
    .addr (req_addr)
  );

  ldnf_elem_view #(.VLB(VLB)) u_view (
    .pred    (pred_q),
    .ffr     (ffr_q),
    .shift   (shift_q),
    .idx     (idx),
    .active  (active),
    .ffr_low (ffr_low),
    .grp_mask(grp_mask)
  );

  always_comb begin
    last_idx  = IW'((HW >> shift_q) - 1);
    slot      = idx << shift_q;
    last_elem = (idx == last_idx);
  end

  assign req_valid = (st == ST_REQ);
  assign rsp_ready = (st == ST_WAIT);
  assign done      = (st == ST_DONE);
  assign result    = res_q;
  assign ffr_out   = ffr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      base_q    <= '0;
      imm_q     <= '0;
      shift_q   <= '0;
      pred_q    <= '0;
      ffr_q     <= '0;
      res_q     <= '0;
      faulted_q <= 1'b0;
      unknown_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            base_q    <= base_addr;
            imm_q     <= imm;
            shift_q   <= size_shift(esize);
            pred_q    <= pred;
            ffr_q     <= ffr_in;
            res_q     <= '0;
            idx       <= '0;
            faulted_q <= 1'b0;
            unknown_q <= 1'b0;
            st        <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (!faulted_q && active) begin
            st <= ST_REQ;
          end else begin
            if (faulted_q) ffr_q <= ffr_q & ~grp_mask;
            else if (!ffr_low) unknown_q <= 1'b1;
            if (last_elem) st <= ST_DONE;
            else idx <= idx + 1'b1;
          end
        end
        ST_REQ: begin
          if (req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_fault) begin
              faulted_q <= 1'b1;
              ffr_q     <= ffr_q & ~grp_mask;
            end else if (unknown_q || !ffr_low) begin
              unknown_q <= 1'b1;
            end else begin
              res_q[{slot, 4'b0000} +: 16] <= rsp_data;
            end
            if (last_elem) st <= ST_DONE;
            else begin
              idx <= idx + 1'b1;
              st  <= ST_SCAN;
            end
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldnf_chk.sv
module ldnf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic        done
);
  logic outst;
  logic fault_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst      <= 1'b0;
      fault_seen <= 1'b0;
    end else begin
      if (req_valid && req_ready) outst <= 1'b1;
      else if (rsp_valid && rsp_ready) outst <= 1'b0;
      if (done) fault_seen <= 1'b0;
      else if (rsp_valid && rsp_ready && rsp_fault) fault_seen <= 1'b1;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !req_valid);

  // R11
  rsp_ready_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> outst);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  no_req_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_seen |-> !req_valid);
endmodule

bind ldnf_seq ldnf_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_fault(rsp_fault),
  .done     (done)
);

// File: tb/sim_ldnf_seq.sv
module sim_ldnf_seq;
  localparam int CLK_PERIOD = 10;
  localparam int VLB = 128;
  localparam int HW  = VLB / 16;
  localparam int PB  = VLB / 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [63:0]    base_addr = '0;
  logic [3:0]     imm = '0;
  logic [1:0]     esize = '0;
  logic [PB-1:0]  pred = '0;
  logic [PB-1:0]  ffr_in = '0;
  logic           req_valid;
  logic           req_ready = 1'b0;
  logic [63:0]    req_addr;
  logic           rsp_valid = 1'b0;
  logic           rsp_ready;
  logic [15:0]    rsp_data = '0;
  logic           rsp_fault = 1'b0;
  logic           done;
  logic [VLB-1:0] result;
  logic [PB-1:0]  ffr_out;

  ldnf_seq #(.VLB(VLB)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  logic [63:0] flo = '0, fhi = '0;

  logic [63:0]    exp_addr_q[$];
  logic [VLB-1:0] exp_res_q[$];
  logic [PB-1:0]  exp_ffr_q[$];
  string          tag_q[$];

  function automatic logic [15:0] mdata(input logic [63:0] a);
    return a[15:0] ^ 16'hC3A5;
  endfunction

  function automatic bit in_win(input logic [63:0] a);
    return (a >= flo) && (a < fhi);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and monitor, all at negedge
  initial begin : mem_mon
    bit pend = 0, rq_fire = 0, rs_fire = 0;
    int dly = 0;
    logic [63:0] pa = '0;
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 0; rq_fire = 0; rs_fire = 0;
        req_ready = 0; rsp_valid = 0;
      end else begin
        if (rs_fire) pend = 0;
        if (rq_fire) begin pend = 1; dly = lfsr[1:0] == 2'd0 ? 2 : 0; end
        else if (pend && dly > 0) dly--;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        req_ready = !pend && lfsr[0];
        rsp_valid = pend && dly == 0;
        rsp_data  = rsp_valid ? mdata(pa) : 16'hxxxx;
        rsp_fault = rsp_valid && in_win(pa);
        rq_fire = req_valid && req_ready;
        rs_fire = rsp_valid && rsp_ready;
        if (rq_fire) begin
          pa = req_addr;
          if (exp_addr_q.size() == 0)
            chk(0, "R4/R5/R7 unexpected request", 128'(req_addr), 128'hx);
          else begin
            logic [63:0] ea;
            ea = exp_addr_q.pop_front();
            chk(req_addr == ea, "R1/R2/R10 request address", 128'(req_addr), 128'(ea));
          end
        end
        if (done) begin
          logic [VLB-1:0] er;
          logic [PB-1:0]  ef;
          string t;
          er = exp_res_q.pop_front();
          ef = exp_ffr_q.pop_front();
          t  = tag_q.pop_front();
          chk(result == er, {t, " result"}, 128'(result), 128'(er));
          chk(ffr_out == ef, {t, " ffr"}, 128'(ffr_out), 128'(ef));
          chk(exp_addr_q.size() == 0, {t, " R5/R7 missing requests"},
              128'(exp_addr_q.size()), 128'd0);
          exp_addr_q.delete();
          done_cnt++;
        end
      end
    end
  end

  task automatic drive(input logic [63:0] b, input logic signed [3:0] im, input logic [1:0] s,
                       input logic [PB-1:0] p, input logic [PB-1:0] f, input string tag,
                       input bit poke);
    int sh = (s == 2'd0) ? 0 : (s == 2'd1) ? 1 : 2;
    int nel = HW >> sh;
    int bb = 2 << sh;
    int w = 16 << sh;
    logic [VLB-1:0] r = '0;
    logic [PB-1:0] ff = f;
    bit flt = 0, unk = 0;
    int target;
    for (int e = 0; e < nel; e++) begin
      if (flt) begin
        for (int q = 0; q < bb; q++) ff[e*bb+q] = 1'b0;
      end else if (!p[e*bb]) begin
        if (!ff[e*bb]) unk = 1;
      end else begin
        logic [63:0] a;
        a = b + 64'((longint'(im) * nel + e) * 2);
        exp_addr_q.push_back(a);
        if (in_win(a)) begin
          flt = 1;
          for (int q = 0; q < bb; q++) ff[e*bb+q] = 1'b0;
        end else begin
          if (!ff[e*bb]) unk = 1;
          if (!unk) r[e*w +: 16] = mdata(a);
        end
      end
    end
    exp_res_q.push_back(r);
    exp_ffr_q.push_back(ff);
    tag_q.push_back(tag);
    target = done_cnt + 1;
    @(negedge clk);
    base_addr = b; imm = im; esize = s; pred = p; ffr_in = f; start = 1;
    @(negedge clk);
    start = 0;
    base_addr = ~b; imm = ~im; pred = ~p; ffr_in = '0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
    // R9: outputs held after done
    chk(result == r && ffr_out == ff, {tag, " R9 hold"}, 128'(result), 128'(r));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [63:0] B0 = 64'h0000_0001_0002_0000;

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !req_valid, "R9 reset state", 128'({done, req_valid}), 128'd0);
    // R1 R3 16-bit elements, all active
    drive(B0, 4'sd0, 2'd0, '1, '1, "R1 R3 h-all", 0);
    // R2 R4 32-bit, imm -8, sparse predicate
    drive(B0, -4'sd8, 2'd1, 16'h0F0F, '1, "R2 R4 s-sparse", 0);
    // R1 R2 64-bit, imm 7
    drive(B0, 4'sd7, 2'd2, 16'h0101, '1, "R1 R2 d-imm7", 0);
    // R6 R7 fault at element 3
    flo = B0 + 6; fhi = B0 + 8;
    drive(B0, 4'sd0, 2'd0, '1, '1, "R6 R7 mid-fault", 0);
    // R4 fault window over an inactive element's address
    flo = B0 - 128 + 2; fhi = B0 - 128 + 4;
    drive(B0, -4'sd8, 2'd0, 16'h1111, '1, "R4 inactive-fault", 0);
    flo = 0; fhi = 0;
    // R8 incoming mask clear at element 1
    drive(B0, 4'sd1, 2'd1, '1, 16'hFF0F, "R8 ffr-clear", 0);
    // R5 no active elements
    drive(B0, 4'sd3, 2'd0, '0, 16'hA5A5, "R5 none-active", 0);
    // R6 fault on first element, 64-bit
    flo = B0; fhi = B0 + 2;
    drive(B0, 4'sd0, 2'd2, '1, '1, "R6 first-fault", 0);
    flo = 0; fhi = 0;
    // R1 R9 code 3 acts as 64-bit, start while busy ignored
    drive(B0, -4'sd1, 2'd3, '1, '1, "R1 R9 code3-poke", 1);
    // R10 R11 back-to-back with wrapping address
    drive(64'hFFFF_FFFF_FFFF_FFF8, 4'sd0, 2'd0, 16'h5555, '1, "R10 R11 wrap", 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule